// File: doc/BRIEF.md
# Spaced Register-Access SPI Host

This block drives a four-wire serial link to a peripheral's register file. Each transfer carries one address byte and one data byte. A requester hands it a read, a write or a burst-exit operation over a valid/ready handshake. Writes shift both bytes out back to back. Reads shift the address, pause, and then clock the data byte in. The byte read back appears on `rd_data`, and `rd_done` pulses for one cycle.

The peripheral needs idle time between accesses, and the amount depends on what was just done. After a write it needs a long pause. After a read it needs only a short one. The pause between the address and data phases of a read is longer for two "slow" registers than for the others. The host tracks the previous operation, times these gaps with cycle counters and holds `req_ready` low until each gap has run out.

The burst-exit operation generates no clocks. It keeps chip select released for a fixed minimum time. All delays and the serial clock half-period are parameters given in clock cycles.

Top module: `spi_cmd_host`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sclk` is 1, `rd_done` is 0 and `req_ready` is 1.
- R2: `req_op` codes are 0 = read, 1 = write, 2 = burst exit; code 3 acts as read. A read or write sends, inside one chip-select-low window, an address byte `{is_write, req_addr[6:0]}` MSB first. It is followed by a data byte MSB first, which is `req_wdata` for writes.
- R3: `spi_mosi` changes only together with a falling `spi_sclk` edge. It is stable for at least `HALF_CYC` cycles before every rising edge and does not change while `spi_sclk` is high.
- R4: For reads, `spi_miso` is sampled on the eight rising edges of the data byte, MSB first. The byte is presented on `rd_data` with a one-cycle `rd_done` pulse in the cycle that chip select is released.
- R5: `spi_sclk` is high whenever `spi_cs_n` is high. Chip select is low for at least `CS_LEAD_CYC` cycles before the first rising clock edge.
- R6: Chip select stays low for at least `CS_LAG_CYC` cycles after the last falling clock edge.
- R7: For a read of any register other than 0x02 and 0x50, at least `AGAP_CYC` cycles separate the last rising edge of the address byte from the first falling edge of the data byte.
- R8: For a read of register 0x02 or 0x50, that gap is at least `AGAP_SLOW_CYC` cycles.
- R9: After a write, chip select stays high for at least `WR_GAP_CYC` cycles before the next transfer, and `req_ready` stays low until then.
- R10: After a read, chip select stays high for at least `RD_GAP_CYC` cycles before the next transfer.
- R11: A burst-exit operation produces no clock edges and keeps chip select high. `req_ready` stays low for at least `EXIT_CYC` cycles after it is accepted.
- R12: A request is taken only in a cycle with `req_valid` and `req_ready` both high. `req_ready` is low from the cycle after acceptance until the operation and its gap are complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Host can take a request |
| req_op | input | 2 | Operation code |
| req_addr | input | 7 | Register address |
| req_wdata | input | 8 | Write data |
| rd_data | output | 8 | Byte returned by the last read |
| rd_done | output | 1 | One-cycle pulse when a read finishes |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Host-to-peripheral data |
| spi_miso | input | 1 | Peripheral-to-host data |

## Verification
The bench starts with directed pairs: write then write, write then read, read then read, read then write, reads of both slow registers and of ordinary ones, and burst exits single and repeated. Each pair selects a different spacing rule, so a wrong gap for any command pair or address class shows up as a chip-select-high or phase gap shorter than required. A run of seeded random operations then mixes ordinary and slow addresses with random data bits. This separates correct bit order and read/write flag placement from mistakes that only appear for particular bit values. A responder on the serial pins decodes every transfer and returns address-dependent data, and line timing is measured on every clock edge.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_EXIT  = 2'd2,
        OP_RSVD  = 2'd3
    } host_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_ADDR,
        ST_AGAP,
        ST_DATA,
        ST_LAG
    } host_st_e;

    typedef struct packed {
        host_op_e    op;
        logic [6:0]  addr;
        logic [7:0]  wdata;
    } host_req_t;

    localparam logic [6:0] SLOW_REG_A = 7'h02;
    localparam logic [6:0] SLOW_REG_B = 7'h50;

    function automatic logic is_slow_reg(input logic [6:0] a);
        return (a == SLOW_REG_A) || (a == SLOW_REG_B);
    endfunction

    function automatic logic is_write_op(input host_op_e op);
        return op == OP_WRITE;
    endfunction

    function automatic logic [7:0] head_byte(input host_req_t r);
        return {is_write_op(r.op), r.addr};
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (rst)
        (load && load_val != '0) |=> !expired) else $error("timer did not arm"); // R12
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int HALF_CYC = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       busy,
    output logic       done
);
    localparam int HW = $clog2(HALF_CYC + 1);

    logic [HW-1:0] half_cnt;
    logic [2:0]    bit_idx;
    logic [7:0]    tx_sh;
    logic          high_phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            half_cnt   <= '0;
            bit_idx    <= '0;
            tx_sh      <= '0;
            high_phase <= 1'b1;
            sclk       <= 1'b1;
            mosi       <= 1'b1;
            rx_byte    <= '0;
            busy       <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy       <= 1'b1;
                    sclk       <= 1'b0;
                    mosi       <= tx_byte[7];
                    tx_sh      <= tx_byte;
                    bit_idx    <= '0;
                    high_phase <= 1'b0;
                    half_cnt   <= HW'(HALF_CYC - 1);
                end
            end else if (half_cnt != '0) begin
                half_cnt <= half_cnt - 1'b1;
            end else if (!high_phase) begin
                sclk       <= 1'b1;
                rx_byte    <= {rx_byte[6:0], miso};
                high_phase <= 1'b1;
                half_cnt   <= HW'(HALF_CYC - 1);
            end else if (bit_idx == 3'd7) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                sclk       <= 1'b0;
                mosi       <= tx_sh[6];
                tx_sh      <= {tx_sh[6:0], 1'b0};
                bit_idx    <= bit_idx + 1'b1;
                high_phase <= 1'b0;
                half_cnt   <= HW'(HALF_CYC - 1);
            end
        end
    end

    AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi)) else $error("mosi moved while clock high"); // R3
    AST_DONE_ON_HIGH: assert property (@(posedge clk) disable iff (rst)
        done |-> (sclk && !busy)) else $error("byte ended with clock low"); // R4
endmodule

// File: rtl/spi_cmd_host.sv
module spi_cmd_host
    import spi_host_pkg::*;
#(
    parameter int HALF_CYC      = 20,
    parameter int CS_LEAD_CYC   = 12,
    parameter int CS_LAG_CYC    = 12,
    parameter int AGAP_CYC      = 5000,
    parameter int AGAP_SLOW_CYC = 7500,
    parameter int WR_GAP_CYC    = 5000,
    parameter int RD_GAP_CYC    = 25,
    parameter int EXIT_CYC      = 400
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output logic       req_ready,
    input  logic [1:0] req_op,
    input  logic [6:0] req_addr,
    input  logic [7:0] req_wdata,
    output logic [7:0] rd_data,
    output logic       rd_done,
    output logic       spi_cs_n,
    output logic       spi_sclk,
    output logic       spi_mosi,
    input  logic       spi_miso
);
    localparam int PH_MAX = max_int(max_int(CS_LEAD_CYC, CS_LAG_CYC),
                                    max_int(AGAP_CYC, AGAP_SLOW_CYC));
    localparam int GP_MAX = max_int(max_int(WR_GAP_CYC, RD_GAP_CYC), EXIT_CYC);
    localparam int PTW    = $clog2(PH_MAX + 1);
    localparam int GTW    = $clog2(GP_MAX + 1);

    host_st_e  st;
    host_req_t cur;
    host_req_t incoming;

    logic           accept;
    logic           ph_load, ph_expired;
    logic [PTW-1:0] ph_val;
    logic           gp_load, gp_expired;
    logic [GTW-1:0] gp_val;
    logic           sh_start, sh_busy, sh_done;
    logic [7:0]     sh_tx, sh_rx;
    logic           cur_write;

    assign incoming  = '{op: host_op_e'(req_op), addr: req_addr, wdata: req_wdata};
    assign req_ready = (st == ST_IDLE) && gp_expired;
    assign accept    = req_valid && req_ready;
    assign cur_write = is_write_op(cur.op);

    always_comb begin
        ph_load = 1'b0;
        ph_val  = '0;
        if (accept && incoming.op != OP_EXIT) begin
            ph_load = 1'b1;
            ph_val  = PTW'(CS_LEAD_CYC);
        end else if (st == ST_ADDR && sh_done && !cur_write) begin
            ph_load = 1'b1;
            ph_val  = is_slow_reg(cur.addr) ? PTW'(AGAP_SLOW_CYC) : PTW'(AGAP_CYC);
        end else if (st == ST_DATA && sh_done) begin
            ph_load = 1'b1;
            ph_val  = PTW'(CS_LAG_CYC);
        end
    end

    always_comb begin
        gp_load = 1'b0;
        gp_val  = '0;
        if (accept && incoming.op == OP_EXIT) begin
            gp_load = 1'b1;
            gp_val  = GTW'(EXIT_CYC);
        end else if (st == ST_LAG && ph_expired) begin
            gp_load = 1'b1;
            gp_val  = cur_write ? GTW'(WR_GAP_CYC) : GTW'(RD_GAP_CYC);
        end
    end

    always_comb begin
        sh_start = 1'b0;
        sh_tx    = 8'h00;
        unique case (st)
            ST_LEAD: begin
                sh_start = ph_expired;
                sh_tx    = head_byte(cur);
            end
            ST_ADDR: begin
                sh_start = sh_done && cur_write;
                sh_tx    = cur.wdata;
            end
            ST_AGAP: begin
                sh_start = ph_expired;
                sh_tx    = 8'h00;
            end
            default: begin
                sh_start = 1'b0;
                sh_tx    = 8'h00;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cur      <= '{op: OP_READ, addr: 7'd0, wdata: 8'd0};
            spi_cs_n <= 1'b1;
            rd_data  <= '0;
            rd_done  <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        cur <= incoming;
                        if (incoming.op != OP_EXIT) begin
                            spi_cs_n <= 1'b0;
                            st       <= ST_LEAD;
                        end
                    end
                end
                ST_LEAD: if (ph_expired) st <= ST_ADDR;
                ST_ADDR: if (sh_done) st <= cur_write ? ST_DATA : ST_AGAP;
                ST_AGAP: if (ph_expired) st <= ST_DATA;
                ST_DATA: begin
                    if (sh_done) begin
                        st <= ST_LAG;
                        if (!cur_write) rd_data <= sh_rx;
                    end
                end
                ST_LAG: begin
                    if (ph_expired) begin
                        st       <= ST_IDLE;
                        spi_cs_n <= 1'b1;
                        rd_done  <= !cur_write;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    spi_gap_timer #(.TW(PTW)) u_phase (
        .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .expired(ph_expired)
    );

    spi_gap_timer #(.TW(GTW)) u_space (
        .clk(clk), .rst(rst), .load(gp_load), .load_val(gp_val), .expired(gp_expired)
    );

    spi_byte_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk(clk), .rst(rst), .start(sh_start), .tx_byte(sh_tx), .miso(spi_miso),
        .sclk(spi_sclk), .mosi(spi_mosi), .rx_byte(sh_rx), .busy(sh_busy), .done(sh_done)
    );

    AST_IDLE_CLOCK_HIGH: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> spi_sclk) else $error("clock low with select released"); // R5
    AST_READY_SELECT_OFF: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (spi_cs_n && !sh_busy)) else $error("ready during transfer"); // R12
    AST_ACCEPT_SELECTS: assert property (@(posedge clk) disable iff (rst)
        (accept && incoming.op != OP_EXIT) |=> !spi_cs_n) else $error("select not asserted"); // R12
    AST_EXIT_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
        (accept && incoming.op == OP_EXIT) |=> (spi_cs_n && !req_ready)) else $error("exit misbehaved"); // R11
    AST_SPACING_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        !gp_expired |-> !req_ready) else $error("ready inside gap"); // R9
    AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> (spi_cs_n && $past(!spi_cs_n))) else $error("done not at release"); // R4
endmodule

// File: tb/sim_spi_cmd_host.sv
module sim_spi_cmd_host;
    localparam int HALF  = 3;
    localparam int LEAD  = 4;
    localparam int LAG   = 4;
    localparam int AGAP  = 30;
    localparam int AGAPS = 45;
    localparam int WRG   = 40;
    localparam int RDG   = 6;
    localparam int EXITC = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_op = 2'd0;
    logic [6:0] req_addr = 7'd0;
    logic [7:0] req_wdata = 8'd0;
    logic [7:0] rd_data;
    logic rd_done;
    logic spi_cs_n, spi_sclk, spi_mosi;
    logic spi_miso = 1'b1;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    spi_cmd_host #(
        .HALF_CYC(HALF), .CS_LEAD_CYC(LEAD), .CS_LAG_CYC(LAG), .AGAP_CYC(AGAP),
        .AGAP_SLOW_CYC(AGAPS), .WR_GAP_CYC(WRG), .RD_GAP_CYC(RDG), .EXIT_CYC(EXITC)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .rd_done(rd_done), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic [7:0] resp_of(input logic [6:0] a);
        return ({a, 1'b1} * 8'd37) ^ 8'h3C;
    endfunction

    function automatic int agap_of(input logic [6:0] a);
        return (a == 7'h02 || a == 7'h50) ? AGAPS : AGAP;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // responder and line-timing monitor, sampled on the falling clock
    logic       p_cs = 1'b1, p_sclk = 1'b1, p_mosi = 1'b1;
    int         bitn = 0;
    logic [15:0] shin = '0;
    logic [7:0] last_head = '0, last_data = '0;
    int         hi_cnt = 0, lo_cnt = 0, mosi_age = 0, since_fall = 0, since_rise = 0;
    bit         seen_rise = 1'b0;
    int         need = 0;
    int         cur_gap_need = 0;
    bit         hold_bad = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            mosi_age   = (spi_mosi != p_mosi) ? 1 : mosi_age + 1;
            since_fall = since_fall + 1;
            since_rise = since_rise + 1;
            if (spi_cs_n) begin
                hi_cnt = hi_cnt + 1;
                if (spi_sclk != p_sclk) check(1'b0, "R5 clock edge with select high", spi_sclk, 1);
            end
            if (p_cs && !spi_cs_n) begin
                check(hi_cnt >= need, "R9/R10/R11 select-high spacing", hi_cnt, need);
                hi_cnt = 0; lo_cnt = 0; bitn = 0; seen_rise = 1'b0; hold_bad = 1'b0;
            end
            if (!spi_cs_n) begin
                lo_cnt = lo_cnt + 1;
                if (p_sclk && spi_sclk && spi_mosi != p_mosi) hold_bad = 1'b1;
                if (!p_sclk && spi_sclk) begin
                    if (!seen_rise) check(lo_cnt >= LEAD, "R5 select lead", lo_cnt, LEAD);
                    seen_rise = 1'b1;
                    check(mosi_age >= HALF, "R3 mosi setup", mosi_age, HALF);
                    shin = {shin[14:0], spi_mosi};
                    bitn = bitn + 1;
                    since_rise = 0;
                    if (bitn == 8) last_head = shin[7:0];
                end
                if (p_sclk && !spi_sclk) begin
                    if (bitn == 8 && !last_head[7])
                        check(since_rise >= agap_of(last_head[6:0]), "R7/R8 address-to-data gap",
                              since_rise, agap_of(last_head[6:0]));
                    if (bitn >= 8 && !last_head[7]) spi_miso = resp_of(last_head[6:0])[15 - bitn];
                    since_fall = 0;
                end
            end
            if (!p_cs && spi_cs_n) begin
                check(since_fall >= LAG, "R6 select lag", since_fall, LAG);
                check(!hold_bad, "R3 mosi hold while clock high", hold_bad, 0);
                check(bitn == 16, "R2 sixteen clocks per transfer", bitn, 16);
                last_data = shin[7:0];
                need = last_head[7] ? WRG : RDG;
                hi_cnt = 1;
            end
            p_cs = spi_cs_n; p_sclk = spi_sclk; p_mosi = spi_mosi;
        end
    end

    task automatic issue(input logic [1:0] op, input logic [6:0] a, input logic [7:0] d);
        int waitc;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R12 ready drops after accept", req_ready, 0);
        if (op == 2'd2) begin
            need = need + EXITC;
            waitc = 1;
            while (!req_ready) begin
                if (!spi_cs_n) check(1'b0, "R11 select during exit", 0, 1);
                @(negedge clk);
                waitc++;
            end
            check(waitc >= EXITC, "R11 exit hold time", waitc, EXITC);
        end else if (op == 2'd1) begin
            while (!req_ready) @(negedge clk);
            check(last_head == {1'b1, a}, "R2 write head byte", last_head, {1'b1, a});
            check(last_data == d, "R2 write data byte", last_data, d);
        end else begin
            while (!rd_done) @(negedge clk);
            check(last_head == {1'b0, a}, "R2 read head byte", last_head, {1'b0, a});
            check(rd_data == resp_of(a), "R4 read data", rd_data, resp_of(a));
            @(negedge clk);
            check(!rd_done, "R4 done is one cycle", rd_done, 0);
        end
    endtask

    initial begin
        while (cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL R12 watchdog expired actual=%0d expected=%0d", cycles, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(spi_cs_n == 1'b1, "R1 select idle", spi_cs_n, 1);
        check(spi_sclk == 1'b1, "R1 clock idle", spi_sclk, 1);
        check(rd_done == 1'b0, "R1 done idle", rd_done, 0);
        check(req_ready == 1'b1, "R1 ready idle", req_ready, 1);
        issue(2'd1, 7'h11, 8'hA5);   // write then write: R9
        issue(2'd1, 7'h7F, 8'h00);
        issue(2'd0, 7'h02, 8'h00);   // write then slow read: R8
        issue(2'd0, 7'h50, 8'h00);   // read then read: R10
        issue(2'd0, 7'h03, 8'h00);   // ordinary read: R7
        issue(2'd1, 7'h00, 8'hFF);   // read then write
        issue(2'd2, 7'h00, 8'h00);   // burst exit: R11
        issue(2'd2, 7'h00, 8'h00);
        issue(2'd0, 7'h51, 8'h00);
        issue(2'd3, 7'h40, 8'h00);   // reserved code behaves as read: R2
        for (int i = 0; i < 30; i++) begin
            logic [1:0] op;
            logic [6:0] a;
            op = 2'($urandom % 3);
            case ($urandom % 4)
                0: a = 7'h02;
                1: a = 7'h50;
                default: a = 7'($urandom);
            endcase
            issue(op, a, 8'($urandom));
        end
        repeat (5) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule